// File: doc/BRIEF.md
# Fractional Clock-Enable Divider

This block turns a free-running input clock into a stream of one-cycle enable pulses whose average spacing is a fixed-point divisor `A + B/256`. The integer part `A` sets the base spacing in input cycles. The fraction `B` stretches some intervals by one cycle. Consumers downstream clock everything on the input clock and qualify their work with the `tick` pulse, so no derived clock is ever formed.

The stretched intervals are chosen by an 8-bit phase accumulator. At the start of every interval it adds `B` to its value, and a carry out makes that interval one cycle longer. Over any 256 consecutive intervals this yields exactly `B` long ones, and they are scattered as evenly as the count allows. A new divisor is written into a holding register by a strobe. It is taken into use only when the current interval ends, or straight away while the divider is stopped, so an interval in progress is never cut short or stretched.

Top module: `frac_tick_div`

## Requirements
- R1: `div_cfg[17:8]` is the integer part A and `div_cfg[7:0]` is the fraction B. With B = 0 and `run` held high, successive `tick` pulses are exactly A input cycles apart.
- R2: An integer part of 0 behaves exactly like an integer part of 1.
- R3: With A and B held constant, every 256 consecutive intervals contain exactly B intervals of A+1 cycles, and the rest last A cycles.
- R4: With a constant divisor, every 16 consecutive intervals contain either floor(16·B/256) or ceil(16·B/256) long intervals.
- R5: `tick` is high for one input cycle at the end of each interval. When A ≥ 2 it is never high in two adjacent cycles. When A = 1 and B = 0 it stays high.
- R6: After `run` rises, the long-interval pattern restarts from a cleared phase. Interval k (counting from 1) is long exactly when floor(k·B/256) > floor((k−1)·B/256), so the first interval is never long. The first tick is seen in the cycle after the A-th rising edge at which `run` is sampled high.
- R7: While `run` is low, `tick` stays low and any partly counted interval is discarded. The next run starts a fresh full interval.
- R8: A `cfg_load` pulse captures `div_cfg`. If the divider is running, the interval under way finishes with its old length and the new divisor governs from the interval after the next tick. If the divider is stopped, the new divisor is in force for the next run.
- R9: After reset, `tick` is low and the active divisor is 1.0, so running without any load gives a tick in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_cfg | input | 18 | Divisor: integer part in [17:8], fraction in [7:0] |
| cfg_load | input | 1 | Strobe that captures `div_cfg` as the pending divisor |
| run | input | 1 | Enable; low stops the divider and clears its interval and phase |
| tick | output | 1 | One-cycle enable pulse at the end of each interval |

## Verification
The bench sweeps every fraction value with a small integer part and checks each interval against the closed-form carry sequence. A design that grouped the long intervals, or that added the fraction one interval late, breaks either the per-interval match or the 16-interval window bound. A mis-sized accumulator breaks the 256-interval count. Separate runs target the remaining corner cases:
- An integer part of 0. A design that counts it literally hangs or emits nothing.
- The largest divisor. A counter that is too narrow wraps early.
- A divisor loaded in mid-interval. A design that switches at once produces one truncated or stretched interval.
- Stopping part way through an interval. A design that keeps the old count or phase gives a short first interval or starts the long-interval pattern in the wrong place.

// File: rtl/frac_tick_div_pkg.sv
// Package: shared defaults and the per-cycle action code that the interval
// counter broadcasts to the divisor holder and the phase accumulator.
// Assumes every module in the divider is compiled after this package.
package frac_tick_div_pkg;

    localparam int DEF_INT_W  = 10;
    localparam int DEF_FRAC_W = 8;

    // What the divider does at the coming clock edge.
    typedef enum logic [1:0] {
        STEP_IDLE  = 2'd0,  // run low: clear count and phase, take any pending divisor
        STEP_COUNT = 2'd1,  // inside an interval: advance the count
        STEP_WRAP  = 2'd2   // last cycle of an interval: emit tick, start the next one
    } step_e;

endpackage

// File: rtl/frac_tick_div_cfg.sv
// Module: divisor holder.
// Keeps a pending divisor written by the load strobe and an active divisor
// used by the counter. The active copy changes only at an interval boundary
// or while idle. An integer part of zero is stored as one.
// Assumes the step code comes from the interval counter of the same divider.
module frac_tick_div_cfg
    import frac_tick_div_pkg::*;
#(
    parameter int INT_W  = DEF_INT_W,
    parameter int FRAC_W = DEF_FRAC_W,
    localparam int CFG_W = INT_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              cfg_load,
    input  step_e             step,
    output logic [INT_W-1:0]  int_eff,
    output logic [FRAC_W-1:0] frac_act,
    output logic [FRAC_W-1:0] frac_next
);

    logic [INT_W-1:0]  pend_int;
    logic [FRAC_W-1:0] pend_frac;
    logic              pend_v;
    logic [INT_W-1:0]  word_int;
    logic              apply;

    // Split the incoming word and map an integer part of zero to one.
    always_comb begin
        word_int = cfg_word[CFG_W-1:FRAC_W];
        if (word_int == '0) begin
            word_int = INT_W'(1);
        end
    end

    // Swap in the pending divisor when an interval ends or the divider is idle.
    assign apply     = (step != STEP_COUNT);
    assign frac_next = pend_v ? pend_frac : frac_act;

    // Capture a newly written divisor into the pending slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_int  <= INT_W'(1);
            pend_frac <= '0;
            pend_v    <= 1'b0;
        end else if (cfg_load) begin
            pend_int  <= word_int;
            pend_frac <= cfg_word[FRAC_W-1:0];
            pend_v    <= 1'b1;
        end else if (apply) begin
            pend_v    <= 1'b0;
        end
    end

    // Update the active divisor only at a safe point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_eff  <= INT_W'(1);
            frac_act <= '0;
        end else if (apply && pend_v) begin
            int_eff  <= pend_int;
            frac_act <= pend_frac;
        end
    end

    a_r8_hold_midrun: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_COUNT) |=> ($stable(int_eff) && $stable(frac_act)));

    a_r2_int_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        int_eff != '0);

endmodule

// File: rtl/frac_tick_div_acc.sv
// Module: phase accumulator.
// Adds the fraction once per interval, at the interval's start. A carry out
// of that addition marks the interval that is starting as one cycle longer.
// The phase is cleared while the divider is idle, so the first interval of a
// run is never long.
// Assumes frac_next is the fraction that governs the interval being started.
module frac_tick_div_acc
    import frac_tick_div_pkg::*;
#(
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_e             step,
    input  logic [FRAC_W-1:0] frac_next,
    output logic              long_q
);

    logic [FRAC_W-1:0] phase;
    logic [FRAC_W:0]   sum;

    // Add the fraction to the phase; the top bit is the carry out.
    assign sum = {1'b0, phase} + {1'b0, frac_next};

    // Advance the phase at each boundary; restart from zero plus B while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= '0;
            long_q <= 1'b0;
        end else begin
            unique case (step)
                STEP_IDLE: begin
                    phase  <= frac_next;
                    long_q <= 1'b0;
                end
                STEP_WRAP: begin
                    phase  <= sum[FRAC_W-1:0];
                    long_q <= sum[FRAC_W];
                end
                default: begin
                    phase  <= phase;
                    long_q <= long_q;
                end
            endcase
        end
    end

    a_r6_idle_short: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_IDLE) |=> !long_q);

endmodule

// File: rtl/frac_tick_div_cnt.sv
// Module: interval counter.
// Counts input cycles from 1 up to the current interval length, which is the
// integer part plus one when the interval is long. It raises tick for one
// cycle after the last count and then starts again at 1. It publishes the
// step code that the other parts follow.
// Assumes the length inputs change only at a boundary or while idle.
module frac_tick_div_cnt
    import frac_tick_div_pkg::*;
#(
    parameter int INT_W = DEF_INT_W,
    localparam int CNT_W = INT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [INT_W-1:0] int_eff,
    input  logic             long_in,
    output step_e            step,
    output logic             tick
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len;

    // Interval length in input cycles.
    assign len = {1'b0, int_eff} + CNT_W'(long_in);

    // Decide what happens at the coming edge.
    always_comb begin
        if (!run) begin
            step = STEP_IDLE;
        end else if (cnt >= len) begin
            step = STEP_WRAP;
        end else begin
            step = STEP_COUNT;
        end
    end

    // Advance the count and register the tick pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= CNT_W'(1);
            tick <= 1'b0;
        end else begin
            unique case (step)
                STEP_WRAP: begin
                    cnt  <= CNT_W'(1);
                    tick <= 1'b1;
                end
                STEP_COUNT: begin
                    cnt  <= cnt + CNT_W'(1);
                    tick <= 1'b0;
                end
                default: begin
                    cnt  <= CNT_W'(1);
                    tick <= 1'b0;
                end
            endcase
        end
    end

    a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= CNT_W'(1)) && (cnt <= len));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick);

endmodule

// File: rtl/frac_tick_div.sv
// Module: fractional clock-enable divider, top level.
// Joins the divisor holder, the phase accumulator and the interval counter.
// The output tick marks the end of each interval, whose average length is
// A + B/256 input cycles.
// Assumes cfg_load and run are synchronous to clk.
module frac_tick_div
    import frac_tick_div_pkg::*;
#(
    parameter int INT_W  = DEF_INT_W,
    parameter int FRAC_W = DEF_FRAC_W,
    localparam int CFG_W = INT_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] div_cfg,
    input  logic             cfg_load,
    input  logic             run,
    output logic             tick
);

    step_e             step;
    logic [INT_W-1:0]  int_eff;
    logic [FRAC_W-1:0] frac_act;
    logic [FRAC_W-1:0] frac_next;
    logic              long_q;

    frac_tick_div_cfg #(.INT_W(INT_W), .FRAC_W(FRAC_W)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_word (div_cfg),
        .cfg_load (cfg_load),
        .step     (step),
        .int_eff  (int_eff),
        .frac_act (frac_act),
        .frac_next(frac_next)
    );

    frac_tick_div_acc #(.FRAC_W(FRAC_W)) acc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .frac_next(frac_next),
        .long_q   (long_q)
    );

    frac_tick_div_cnt #(.INT_W(INT_W)) cnt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .int_eff(int_eff),
        .long_in(long_q),
        .step   (step),
        .tick   (tick)
    );

    a_r3_long_needs_frac: assert property (@(posedge clk) disable iff (!rst_n)
        long_q |-> (frac_act != '0));

endmodule

// File: tb/frac_tick_div_tb_top.sv
module frac_tick_div_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] div_cfg = '0;
    logic        cfg_load = 1'b0;
    logic        run = 1'b0;
    logic        tick;

    int n_run = 0;
    int n_fail = 0;
    int iv [0:299];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    frac_tick_div dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_cfg (div_cfg),
        .cfg_load(cfg_load),
        .run     (run),
        .tick    (tick)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected length of interval k (from 1) after a fresh start.
    function automatic int exp_len(input int a, input int b, input int k);
        int ae = (a == 0) ? 1 : a;
        return ae + ((k * b) / 256 - ((k - 1) * b) / 256);
    endfunction

    // Load a divisor while stopped; returns at a negedge with run low.
    task automatic load_idle(input int a, input int b);
        @(negedge clk);
        run      = 1'b0;
        div_cfg  = {a[9:0], b[7:0]};
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Record n interval lengths, counting negedges since the last tick.
    task automatic collect(input int n, input int start);
        int c = start;
        int k = 0;
        while (k < n) begin
            @(negedge clk);
            c++;
            if (tick) begin
                iv[k] = c;
                k++;
                c = 0;
            end
        end
    endtask

    // Full check of one constant divisor run of n intervals.
    task automatic sweep_one(input int a, input int b, input int n);
        load_idle(a, b);
        run = 1'b1;
        collect(n, 0);
        for (int k = 0; k < n; k++) begin
            chk(iv[k] == exp_len(a, b, k + 1), (b == 0) ? "R1" : "R6", iv[k], exp_len(a, b, k + 1));
        end
        if (n >= 256) begin
            for (int s = 0; s + 256 <= n; s += 4) begin
                int longs = 0;
                int ae = (a == 0) ? 1 : a;
                for (int k = s; k < s + 256; k++) longs += (iv[k] > ae) ? 1 : 0;
                chk(longs == b, "R3", longs, b);
            end
        end
        if (n >= 16) begin
            for (int s = 0; s + 16 <= n; s++) begin
                int longs = 0;
                int ae = (a == 0) ? 1 : a;
                int lo = (16 * b) / 256;
                int hi = lo + (((16 * b) % 256) != 0 ? 1 : 0);
                for (int k = s; k < s + 16; k++) longs += (iv[k] > ae) ? 1 : 0;
                chk(longs >= lo && longs <= hi, "R4", longs, lo);
            end
        end
        run = 1'b0;
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin : main
        int cnt_hi;
        bit prev;
        repeat (3) @(negedge clk);
        chk(tick == 1'b0, "R9", tick, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tick == 1'b0, "R9", tick, 0);

        // R9: default divisor 1.0 -> tick every cycle
        run = 1'b1;
        collect(4, 0);
        for (int k = 0; k < 4; k++) chk(iv[k] == 1, "R9", iv[k], 1);
        run = 1'b0;

        // R5: A=2 -> one tick every other cycle, never adjacent
        load_idle(2, 0);
        run = 1'b1;
        collect(1, 0);
        cnt_hi = 0;
        prev = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tick) cnt_hi++;
            chk(!(tick && prev), "R5", int'(tick), 0);
            prev = tick;
        end
        chk(cnt_hi == 10, "R5", cnt_hi, 10);
        run = 1'b0;

        // R1/R3/R4/R6: every fraction with A=1
        for (int b = 0; b < 256; b++) sweep_one(1, b, 260);
        sweep_one(5, 200, 260);
        sweep_one(3, 0, 20);

        // R2: integer part zero acts as one
        sweep_one(0, 77, 20);
        for (int k = 0; k < 4; k++) chk(iv[k] == exp_len(1, 77, k + 1), "R2", iv[k], exp_len(1, 77, k + 1));

        // largest divisor
        sweep_one(1023, 255, 3);

        // R7: stop mid-interval, restart gives full fresh interval and phase
        load_idle(6, 128);
        run = 1'b1;
        repeat (3) @(negedge clk);
        run = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(tick == 1'b0, "R7", tick, 0);
        end
        run = 1'b1;
        collect(3, 0);
        chk(iv[0] == 6, "R7", iv[0], 6);
        chk(iv[1] == 7, "R7", iv[1], 7);
        chk(iv[2] == 6, "R7", iv[2], 6);
        run = 1'b0;

        // R8: load while running takes effect after the current interval
        load_idle(4, 0);
        run = 1'b1;
        collect(1, 0);
        chk(iv[0] == 4, "R8", iv[0], 4);
        @(negedge clk);
        div_cfg  = {10'd7, 8'd0};
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        collect(3, 2);
        chk(iv[0] == 4, "R8", iv[0], 4);
        chk(iv[1] == 7, "R8", iv[1], 7);
        chk(iv[2] == 7, "R8", iv[2], 7);
        run = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule